// File: doc/BRIEF.md
# Sequential Booth Multiplier with Selectable Digit Width

This block multiplies two signed two's-complement operands over several clock cycles by Booth recoding. When it is idle, a one-cycle start pulse loads the multiplicand and the multiplier into internal registers. The block then retires a fixed group of multiplier bits on every clock. For each group it forms one Booth digit from the group and the bit shifted out on the previous step. It adds that digit's multiple of the multiplicand to a partial-product accumulator and shifts the working register arithmetically right by the group size.

The group size is a compile-time parameter and may be 1, 2 or 4. A larger group needs fewer cycles but more adders and a wider selection. The accumulator carries as many guard bits as the group size, so the largest multiple cannot overflow it. The port list and the start/ready handshake are the same for every group size. Surrounding control therefore waits on the ready flag and does not count cycles, and one setting can replace another with no other change.

Top module: `booth_mul`

## Requirements
- R1: While the block is idle (after reset or while `ready` is high), `start` high at a rising edge captures `mcand` and `mplier`, and `ready` is low from the following cycle.
- R2: The completed `product` equals the signed product of the captured operands as a 2·W-bit two's-complement value. This includes the most negative operand squared, zero operands and ±1 operands.
- R3: `ready` rises exactly W/B rising edges after the capturing edge and is never high while an operation is in progress (B = bits retired per cycle).
- R4: Once high, `ready` and `product` hold their values until the next accepted `start`.
- R5: `start` asserted while an operation is in progress is ignored: the running operation's result and completion cycle are unchanged.
- R6: After reset, `ready` is 0 and `product` is 0.
- R7: Builds with B = 1, 2 and 4 (B dividing W) give identical `product` values for the same operands, through the same ports and handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| ready | output | 1 | Product valid, held until the next accepted start |
| product | output | 2·W | Signed product |

## Verification
A start accepted at a rising edge drops `ready` in the next cycle. The product is then due exactly W/B edges after that capture edge, which is 16, 8 or 4 edges for the three builds. The bench model counts these edges per build and predicts `ready` and `product` for every cycle. Outputs are sampled on the falling edge, half a period after the edge that updates them, so the prediction for each cycle lines up with the registered value. A start issued during an operation must leave this schedule untouched, and the model checks that the result and the completion edge match the first operation.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Recoded weight of one adjacent bit pair: 00/11 -> 0, 01 -> +1, 10 -> -1
  function automatic int pair_weight(logic cur, logic prv);
    return int'(prv) - int'(cur);
  endfunction

  // Number of clock steps for an operand width and group size
  function automatic int step_count(int width, int grp);
    return width / grp;
  endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc #(
  parameter int B = 2
) (
  input  logic [B-1:0]       grp_bits,
  input  logic               prev_bit,
  output logic signed [B:0]  digit
);
  import booth_pkg::*;

  always_comb begin
    int sum;
    sum = pair_weight(grp_bits[0], prev_bit);
    for (int i = 1; i < B; i++) begin
      sum = sum + (pair_weight(grp_bits[i], grp_bits[i-1]) << i);
    end
    digit = (B+1)'(sum);
  end

endmodule

// File: rtl/booth_cand_sel.sv
module booth_cand_sel #(
  parameter int W = 16,
  parameter int B = 2
) (
  input  logic signed [W+B-1:0] acc,
  input  logic [W-1:0]          mcand,
  input  logic signed [B:0]     digit,
  output logic signed [W+B-1:0] acc_nxt
);
  localparam int AW   = W + B;
  localparam int HALF = 1 << (B - 1);
  localparam int NC   = 2 * HALF + 1;

  logic signed [AW-1:0] mext;
  logic [AW-1:0]        cand [NC];
  logic [B:0]           idx;

  assign mext = {{B{mcand[W-1]}}, mcand};
  assign idx  = $unsigned(digit) + (B+1)'(HALF);

  // One candidate per digit value, digit -HALF .. +HALF
  for (genvar k = 0; k < NC; k++) begin : g_cand
    localparam int K = k - HALF;
    assign cand[k] = acc + $signed(AW'(K)) * mext;
  end

  assign acc_nxt = cand[idx];

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign load   = start && !busy;
  assign finish = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= CW'(STEPS);
    else if (busy) cnt_q <= cnt_q - CW'(1);
  end

endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int W = 16,
  parameter int B = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           ready,
  output logic [2*W-1:0] product
);
  localparam int AW    = W + B;
  localparam int STEPS = booth_pkg::step_count(W, B);
  localparam int RW    = AW + W + 1;

  logic signed [AW-1:0] acc_q, acc_nxt;
  logic [W-1:0]         mul_q, mcand_q;
  logic                 prev_q;
  logic                 ready_q;
  logic [2*W-1:0]       product_q;
  logic signed [B:0]    digit;

  // Named events for the checker
  logic load_evt, busy, finish_evt;

  logic signed [RW-1:0] work_raw, work_sh;
  logic [AW-1:0]        acc_sh;
  logic [W-1:0]         mul_sh;
  logic                 prev_sh;

  booth_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load_evt), .busy(busy), .finish(finish_evt)
  );

  booth_digit_enc #(.B(B)) u_enc (
    .grp_bits(mul_q[B-1:0]), .prev_bit(prev_q), .digit(digit)
  );

  booth_cand_sel #(.W(W), .B(B)) u_sel (
    .acc(acc_q), .mcand(mcand_q), .digit(digit), .acc_nxt(acc_nxt)
  );

  assign work_raw = {acc_nxt, mul_q, prev_q};
  assign work_sh  = work_raw >>> B;
  assign acc_sh   = work_sh[RW-1 -: AW];
  assign mul_sh   = work_sh[W:1];
  assign prev_sh  = work_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      mul_q     <= '0;
      prev_q    <= 1'b0;
      mcand_q   <= '0;
      ready_q   <= 1'b0;
      product_q <= '0;
    end else if (load_evt) begin
      acc_q   <= '0;
      mul_q   <= mplier;
      prev_q  <= 1'b0;
      mcand_q <= mcand;
      ready_q <= 1'b0;
    end else if (busy) begin
      acc_q  <= acc_sh;
      mul_q  <= mul_sh;
      prev_q <= prev_sh;
      if (finish_evt) begin
        ready_q   <= 1'b1;
        product_q <= {acc_sh[W-1:0], mul_sh};
      end
    end
  end

  assign ready   = ready_q;
  assign product = product_q;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 16,
  parameter int B = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           ready,
  input logic [2*W-1:0] product,
  input logic           busy,
  input logic           load_evt,
  input logic           finish_evt,
  input logic [W-1:0]   mcand_q
);
  localparam int STEPS = W / B;

  logic signed [2*W-1:0] exp_q;
  int                    lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      lat_q <= 0;
    end else if (load_evt) begin
      exp_q <= $signed({{W{mcand[W-1]}}, mcand}) * $signed({{W{mplier[W-1]}}, mplier});
      lat_q <= 0;
    end else if (busy) begin
      lat_q <= lat_q + 1;
    end
  end

  p_load_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> busy && !ready);

  p_prod_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> product == exp_q);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |-> lat_q == STEPS - 1);

  p_not_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !start |=> ready && $stable(product));

  p_ignore_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand_q));

endmodule

bind booth_mul booth_mul_chk #(.W(W), .B(B)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
  .ready(ready), .product(product), .busy(busy), .load_evt(load_evt),
  .finish_evt(finish_evt), .mcand_q(mcand_q)
);

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic           rdy  [NB];
  logic [2*W-1:0] prod [NB];

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar gi = 0; gi < NB; gi++) begin : g_cfg
    localparam int BB = (gi == 0) ? 1 : (gi == 1) ? 2 : 4;
    booth_mul #(.W(W), .B(BB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(a), .mplier(b),
      .ready(rdy[gi]), .product(prod[gi])
    );
  end

  // Behavioural model: remaining steps, expected flag and product per build
  int     rem     [NB];
  int     steps   [NB] = '{16, 8, 4};
  bit     m_rdy   [NB];
  longint m_prod  [NB];
  longint pend    [NB];

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < NB; i++) begin
      if (!rst_n) begin
        rem[i] = 0; m_rdy[i] = 1'b0; m_prod[i] = 0;
      end else if (rem[i] > 0) begin
        rem[i] = rem[i] - 1;
        if (rem[i] == 0) begin
          m_rdy[i] = 1'b1; m_prod[i] = pend[i];
        end
      end else if (start) begin
        pend[i]  = longint'($signed(a)) * longint'($signed(b));
        rem[i]   = steps[i];
        m_rdy[i] = 1'b0;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-cycle comparison, half a period after the updating edge
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < NB; i++) begin
        check(rdy[i] == m_rdy[i], "R3 R4 ready", longint'(rdy[i]), longint'(m_rdy[i]));
        if (m_rdy[i])
          check(longint'($signed(prod[i])) == m_prod[i], "R2 R4 product",
                longint'($signed(prod[i])), m_prod[i]);
      end
    end
  end

  task automatic run_op(logic [W-1:0] x, logic [W-1:0] y, bit hit_busy);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NB; i++)
      check(rdy[i] == 1'b0, "R1 capture", longint'(rdy[i]), 0);
    if (hit_busy) begin
      @(negedge clk);
      a = ~x; b = y ^ 16'h5a5a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int c = 0; c < 18; c++) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      if (hit_busy)
        check(longint'($signed(prod[i])) == longint'($signed(x)) * longint'($signed(y)),
              "R5 busy start ignored", longint'($signed(prod[i])),
              longint'($signed(x)) * longint'($signed(y)));
      check(prod[i] == prod[0], "R7 builds agree",
            longint'($signed(prod[i])), longint'($signed(prod[0])));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      check(rdy[i] == 1'b0, "R6 reset ready", longint'(rdy[i]), 0);
      check(prod[i] == '0, "R6 reset product", longint'(prod[i]), 0);
    end
    cmp_on = 1'b1;
    // R2 corner cases
    run_op(16'h8000, 16'h8000, 1'b0);
    run_op(16'h0000, 16'h1234, 1'b0);
    run_op(16'hbeef, 16'h0000, 1'b0);
    run_op(16'h0001, 16'h8001, 1'b0);
    run_op(16'hffff, 16'h7fff, 1'b0);
    run_op(16'h7fff, 16'hffff, 1'b0);
    run_op(16'h7fff, 16'h8000, 1'b0);
    run_op(16'hffff, 16'hffff, 1'b0);
    // R5 start during an operation
    run_op(16'h1357, 16'hc001, 1'b1);
    run_op(16'h8000, 16'h7fff, 1'b1);
    // R2 R7 random operands
    for (int n = 0; n < 60; n++)
      run_op(W'($urandom), W'($urandom), 1'b0);
    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule